// File: doc/BRIEF.md
# Programmable Interval Countdown Timer

This block is a 32-bit down-counter placed behind a small word-addressed register bus. Software loads a reload value, then starts the counter with a command bit in the control word. The counter steps down by one per clock while running. When it runs out, it raises a sticky timeout flag. In one-shot operation it then halts at zero. In continuous operation it reloads from the stored period and keeps going. A level interrupt is the timeout flag gated by an enable bit. A read-only word returns the live count.

The bus has separate read and write strobes, a byte address and 32-bit data in each direction. The two low address bits are ignored, so the four words sit at byte offsets 0x0, 0x4, 0x8 and 0xC. Read data comes out of a register: it appears one clock after the read strobe and holds until the next read. If the address is widened, any offset above the four words reads as zero. This is a control and status interface, so the pins carry no valid/ready handshake. Every access completes in the cycle its strobe is sampled.

Top module: `cdown_timer`

## Requirements
- R1: The word index is taken from address bits [3:2]: 0 is status, 1 is control, 2 is period, 3 is snapshot. Address bits [1:0] are ignored. Read data is registered: `bus_rdata` carries the addressed word as it stood at the clock edge that sampled `bus_rd`, and it holds until the next read.
- R2: After reset, every register and the counter read as zero, the counter is halted and `irq` is low.
- R3: A period write (word 2) stores the data and loads it into the counter at the same edge. It overrides any countdown or reload in that cycle.
- R4: Any write to status (word 0) clears the timeout flag whatever the data. If a timeout happens at the same edge, the flag ends up set.
- R5: A status read returns the timeout flag in bit 0 and the running state in bit 1, with all other bits zero. Writing status never changes the running state.
- R6: Control (word 1) stores bit 0 interrupt enable, bit 1 continuous mode, bit 2 start and bit 3 stop. It reads back those four bits with the rest zero. Start sets the running state and stop clears it. When both are written together, the counter ends up halted.
- R7: While running, the counter drops by one at every edge. The first decrement happens at the edge after the start write.
- R8: An edge at which the counter is running with a count of 1 (or 0) is a timeout and sets the flag. In one-shot mode the counter ends at 0 and the running state clears.
- R9: In continuous mode a timeout reloads the counter from the period register and the running state stays set.
- R10: `irq` is high exactly when the timeout flag and the interrupt-enable bit are both set. It follows the registers one edge after the write or timeout that changes them.
- R11: A snapshot read (word 3) returns the live counter value. Writes to word 3 change nothing.
- R12: Starting with a count of 0 gives a timeout at the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_rd | input | 1 | Read strobe, sampled at the rising edge |
| bus_addr | input | AW (4) | Byte address of the access |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Registered read data, valid from one edge after `bus_rd` |
| irq | output | 1 | Level interrupt: timeout flag AND interrupt enable |

## Verification
Every register effect of a write shows one edge after the write strobe: stored words, the counter load, run state, flag and `irq`. Read data shows one edge after the read strobe and reflects the state before that edge. After a start write at edge E with count P, the snapshot read at edge E+k returns P-k+1, and the timeout lands at edge E+P. The driver presents each access half a cycle ahead of its edge and pushes the expected word into a queue. The monitor pops and compares on the falling edge after each read edge, and interrupt checks are placed on exact falling edges counted from the write that caused them. The same-edge conflicts (a flag clear meeting a timeout, start and stop together, a period write into a running count) are each set up on a known edge.

// File: rtl/cdown_timer_pkg.sv
package cdown_timer_pkg;

  // word indices (address bits [3:2])
  localparam logic [1:0] WORD_STATUS = 2'd0;
  localparam logic [1:0] WORD_CTRL   = 2'd1;
  localparam logic [1:0] WORD_PERIOD = 2'd2;
  localparam logic [1:0] WORD_SNAP   = 2'd3;

  localparam int CTRL_BITS = 4;

  // control word, bit 3 down to bit 0
  typedef struct packed {
    logic stop;
    logic start;
    logic cont;
    logic ien;
  } ctrl_t;

  // status word, low bits
  typedef struct packed {
    logic running;
    logic timeout;
  } stat_t;

endpackage

// File: rtl/cdown_regbank.sv
module cdown_regbank
  import cdown_timer_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] cnt,
  input  logic          run,
  input  logic          flag,
  output logic          wr_stat,
  output logic          wr_ctrl,
  output logic          wr_per,
  output ctrl_t         ctrl,
  output logic [DW-1:0] period,
  output logic [DW-1:0] rdata
);

  localparam int STAT_W = $bits(stat_t);

  logic [1:0] word;
  logic       in_range;
  logic       unused_lsb;

  assign word       = bus_addr[3:2];
  assign unused_lsb = ^bus_addr[1:0];

  // offsets beyond the four words decode to nothing
  generate
    if (AW > 4) begin : g_wide
      assign in_range = (bus_addr[AW-1:4] == '0);
    end else begin : g_narrow
      assign in_range = 1'b1;
    end
  endgenerate

  assign wr_stat = bus_wr && in_range && (word == WORD_STATUS);
  assign wr_ctrl = bus_wr && in_range && (word == WORD_CTRL);
  assign wr_per  = bus_wr && in_range && (word == WORD_PERIOD);

  // stored words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      period <= '0;
    end else begin
      if (wr_ctrl) ctrl   <= ctrl_t'(bus_wdata[CTRL_BITS-1:0]);
      if (wr_per)  period <= bus_wdata;
    end
  end

  // read path
  stat_t         stat;
  logic [DW-1:0] rd_mux;

  assign stat = '{running: run, timeout: flag};

  always_comb begin
    rd_mux = '0;
    if (in_range) begin
      unique case (word)
        WORD_STATUS: rd_mux[STAT_W-1:0]    = stat;
        WORD_CTRL:   rd_mux[CTRL_BITS-1:0] = ctrl;
        WORD_PERIOD: rd_mux                = period;
        WORD_SNAP:   rd_mux                = cnt;
        default:     rd_mux                = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (bus_rd) rdata <= rd_mux;
  end

endmodule

// File: rtl/cdown_counter.sv
module cdown_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          cmd_start,
  input  logic          cmd_stop,
  input  logic          cont,
  input  logic [DW-1:0] period,
  output logic [DW-1:0] cnt,
  output logic          run,
  output logic          expire
);

  localparam logic [DW-1:0] ONE = DW'(1);

  // a running count at 1 or 0 runs out at this edge
  assign expire = run && (cnt <= ONE);

  logic [DW-1:0] cnt_nx;
  logic          run_nx;

  always_comb begin
    cnt_nx = cnt;
    if (load)        cnt_nx = load_val;
    else if (expire) cnt_nx = cont ? period : '0;
    else if (run)    cnt_nx = cnt - ONE;
  end

  always_comb begin
    run_nx = run;
    if (expire && !cont) run_nx = 1'b0;
    if (cmd_start)       run_nx = 1'b1;
    if (cmd_stop)        run_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else begin
      cnt <= cnt_nx;
      run <= run_nx;
    end
  end

endmodule

// File: rtl/cdown_flag.sv
module cdown_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr,
  input  logic ien,
  output logic flag,
  output logic irq
);

  // a timeout at the clearing edge wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (expire) flag <= 1'b1;
    else if (clr)    flag <= 1'b0;
  end

  assign irq = flag & ien;

endmodule

// File: rtl/cdown_timer.sv
module cdown_timer
  import cdown_timer_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);

  logic          wr_stat, wr_ctrl, wr_per;
  ctrl_t         ctrl_w;
  logic [DW-1:0] period_w, cnt_w;
  logic          run_w, expire_w, flag_w;
  logic          cont_w, ien_w;
  logic          start_cmd, stop_cmd;

  assign cont_w    = ctrl_w.cont;
  assign ien_w     = ctrl_w.ien;
  assign start_cmd = wr_ctrl && bus_wdata[2];
  assign stop_cmd  = wr_ctrl && bus_wdata[3];

  cdown_regbank #(.DW(DW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt       (cnt_w),
    .run       (run_w),
    .flag      (flag_w),
    .wr_stat   (wr_stat),
    .wr_ctrl   (wr_ctrl),
    .wr_per    (wr_per),
    .ctrl      (ctrl_w),
    .period    (period_w),
    .rdata     (bus_rdata)
  );

  cdown_counter #(.DW(DW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wr_per),
    .load_val  (bus_wdata),
    .cmd_start (start_cmd),
    .cmd_stop  (stop_cmd),
    .cont      (cont_w),
    .period    (period_w),
    .cnt       (cnt_w),
    .run       (run_w),
    .expire    (expire_w)
  );

  cdown_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .expire (expire_w),
    .clr    (wr_stat),
    .ien    (ien_w),
    .flag   (flag_w),
    .irq    (irq)
  );

endmodule

// File: rtl/cdown_timer_chk.sv
module cdown_timer_chk #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          irq,
  input logic [DW-1:0] cnt,
  input logic [DW-1:0] period,
  input logic          run,
  input logic          flag,
  input logic          cont
);

  logic [1:0] word;
  logic       per_wr, ctl_wr, near_end;
  logic       unused_chk;

  assign word       = bus_addr[3:2];
  assign per_wr     = bus_wr && (word == 2'd2);
  assign ctl_wr     = bus_wr && (word == 2'd1);
  assign near_end   = run && (cnt <= DW'(1));
  assign unused_chk = ^{bus_addr[1:0], bus_rdata[1:0]};

  // R3
  a_r3_period_load: assert property (@(posedge clk) disable iff (!rst_n)
    per_wr |=> (cnt == $past(bus_wdata)) && (period == $past(bus_wdata)));

  // R4
  a_r4_timeout_sets: assert property (@(posedge clk) disable iff (!rst_n)
    near_end |=> flag);

  // R5
  a_r5_status_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && word == 2'd0) |=> (bus_rdata[DW-1:2] == '0));

  // R6
  a_r6_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && bus_wdata[3]) |=> !run);

  // R7
  a_r7_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt > DW'(1) && !per_wr) |=> (cnt == $past(cnt) - DW'(1)));

  // R8
  a_r8_oneshot_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (near_end && !cont && !per_wr && !ctl_wr) |=> (!run && cnt == '0));

  // R9
  a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (near_end && cont && !per_wr && !ctl_wr) |=> (run && cnt == $past(period)));

  // R10
  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

endmodule

bind cdown_timer cdown_timer_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .cnt       (cnt_w),
  .period    (period_w),
  .run       (run_w),
  .flag      (flag_w),
  .cont      (cont_w)
);

// File: tb/cdown_timer_test.sv
module cdown_timer_test;

  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [DW-1:0] val;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  logic rd_q = 1'b0;

  always #5 clk = ~clk;

  cdown_timer #(.DW(DW), .AW(AW)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  // monitor: a read sampled at a rising edge is due by the next falling edge
  always @(posedge clk) rd_q <= bus_rd;

  always @(negedge clk) begin
    if (rd_q) begin
      exp_t e;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL read with empty scoreboard: got %h", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        if (bus_rdata !== e.val) begin
          errors++;
          $display("FAIL %s: rdata=%h expected %h", e.tag, bus_rdata, e.val);
        end
      end
    end
  end

  // all tasks start and end on a falling edge
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    exp_t x;
    x.val = e; x.tag = tag;
    exp_q.push_back(x);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq=%b expected %b", tag, irq, e);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    chk_irq(1'b0, "R2 irq after reset");
    rd(4'h0, 32'h0, "R2 status after reset");
    rd(4'h4, 32'h0, "R2 control after reset");
    rd(4'h8, 32'h0, "R2 period after reset");
    rd(4'hC, 32'h0, "R2 snapshot after reset");

    // R3 period load while halted
    wr(4'h8, 32'd10);
    rd(4'h8, 32'd10, "R3 period readback");
    rd(4'hC, 32'd10, "R3 counter loaded by period write");

    // one-shot with interrupt enabled: start at edge E
    wr(4'h4, 32'h5);
    rd(4'h0, 32'h2, "R5 status running, no timeout");
    rd(4'hC, 32'd9, "R7 first decrement one edge after start");
    idle(7);
    chk_irq(1'b0, "R8 no timeout before count reaches zero");
    idle(1);
    chk_irq(1'b1, "R10 irq on timeout with enable");
    rd(4'h0, 32'h1, "R8 one-shot timeout clears running");
    rd(4'hC, 32'h0, "R8 one-shot halts at zero");
    rd(4'h4, 32'h5, "R6 control readback");

    // R4 status write clears flag, data ignored
    wr(4'h0, 32'hFFFF_FFFF);
    chk_irq(1'b0, "R4 irq drops after status write");
    rd(4'h0, 32'h0, "R5 status write does not set running");

    // R9 continuous mode, interrupt disabled
    wr(4'h8, 32'd4);
    wr(4'h4, 32'h6);
    rd(4'hC, 32'd4, "R9 count 4");
    rd(4'hC, 32'd3, "R9 count 3");
    rd(4'hC, 32'd2, "R9 count 2");
    rd(4'hC, 32'd1, "R9 count 1");
    rd(4'hC, 32'd4, "R9 reload from period");
    rd(4'h0, 32'h3, "R9 still running with timeout flag");
    chk_irq(1'b0, "R10 irq gated off by enable");
    wr(4'h4, 32'h7);
    chk_irq(1'b1, "R10 irq follows enable write");
    wr(4'h4, 32'h8);
    chk_irq(1'b0, "R10 irq drops with enable cleared");
    rd(4'h0, 32'h1, "R6 stop halts counter");
    rd(4'hC, 32'd4, "R6 halted count after reload");
    idle(3);
    rd(4'hC, 32'd4, "R6 halted count holds");

    // R6 start and stop in one write
    wr(4'h0, 32'h0);
    wr(4'h4, 32'hC);
    rd(4'h0, 32'h0, "R6 start with stop stays halted");
    rd(4'h4, 32'hC, "R6 control readback start+stop");
    idle(2);
    rd(4'hC, 32'd4, "R6 count unchanged when halted");

    // R11 snapshot write ignored; R1 low address bits ignored
    wr(4'hC, 32'h55);
    rd(4'hC, 32'd4, "R11 snapshot write ignored");
    rd(4'h9, 32'd4, "R1 byte offset 9 reads period");
    rd(4'h3, 32'h0, "R1 byte offset 3 reads status");

    // R3 period write into a running count
    wr(4'h8, 32'd100);
    wr(4'h4, 32'h6);
    rd(4'hC, 32'd100, "R7 count before first decrement");
    wr(4'h8, 32'd7);
    rd(4'hC, 32'd7, "R3 period write overrides countdown");
    rd(4'hC, 32'd6, "R7 countdown resumes from new value");
    wr(4'h4, 32'h8);
    wr(4'h0, 32'h0);

    // R12 zero count
    wr(4'h8, 32'd0);
    wr(4'h4, 32'h5);
    rd(4'h0, 32'h2, "R12 running before zero timeout");
    rd(4'h0, 32'h1, "R12 timeout at next edge");
    chk_irq(1'b1, "R12 irq after zero timeout");
    rd(4'hC, 32'h0, "R12 count stays zero");

    // R4 timeout and status clear on the same edge
    wr(4'h0, 32'h0);
    wr(4'h8, 32'd3);
    wr(4'h4, 32'h5);
    idle(2);
    wr(4'h0, 32'h0);
    rd(4'h0, 32'h1, "R4 timeout wins over same-edge clear");
    chk_irq(1'b1, "R4 irq stays high");

    idle(2);
    done = 1;
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R1 reads left pending: %0d expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule